// File: doc/BRIEF.md
# Field-Extended Memory Address Unit

This unit sits between a 12-bit processor core and a 32K-word memory. It forms the 15-bit physical address of every access by putting a 3-bit field number above the 12-bit word address. Two field registers are kept:

- One field register serves instruction fetches.
- The other serves data references.

The unit also computes the program counter for the next step. That value wraps inside the current 4K field and never spills into the field bits.

On a data reference, the low 12 bits come from a 7-bit offset. The offset is placed either in page zero or in the page the PC is currently on. A jump takes the same effective address as its target. A new instruction field is held pending until the next jump. This lets the instruction that loads the field finish from the old field. The data field changes at once.

Every output is registered. A result appears on the clock edge after the access is presented.

Top module: `fext_addr_unit`

## Requirements
- R1: After reset, addr_valid is 0, phys_addr is 0 and next_pc is 0. Both field registers start at field 0, so the first fetch after reset reads field 0.
- R2: An access with acc_en=1 and acc_data=0 (a fetch) gives addr_valid=1 one clock later. It also gives phys_addr = {instruction field, pc_in}.
- R3: An access with acc_data=1 and cur_page=0 gives phys_addr = {data field, 5'b0, ofs} one clock later.
- R4: An access with acc_data=1 and cur_page=1 gives phys_addr = {data field, pc_in[11:7], ofs} one clock later.
- R5: Without jump_en, next_pc is pc_in+1 modulo 4096. For example, 4095 is followed by 0. The instruction field is unchanged by the wrap.
- R6: With jump_en, next_pc is the effective address. That is {pc_in[11:7], ofs} when cur_page=1, or {5'b0, ofs} when cur_page=0.
- R7: if_load stores if_val as a pending field. Fetches keep using the old instruction field, including the fetch in the jump cycle itself. The pending value takes effect for fetches after the next access that has jump_en=1.
- R8: If if_load and jump_en occur in the same access, the jump installs the value that was pending before that access. The newly loaded value waits for a later jump.
- R9: df_load stores df_val as the data field. It applies to data accesses presented from the following cycle on. Fetch addresses never use it.
- R10: While acc_en=0, addr_valid goes to 0 one clock later, and phys_addr and next_pc hold. A jump_en presented with acc_en=0 commits no pending field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access presented this cycle |
| acc_data | input | 1 | 1 = data reference, 0 = instruction fetch |
| pc_in | input | 12 | Current program counter |
| ofs | input | 7 | Offset field of the instruction |
| cur_page | input | 1 | 1 = offset on the PC's page, 0 = page zero |
| jump_en | input | 1 | This access is a jump to the effective address |
| if_load | input | 1 | Load a pending instruction field |
| if_val | input | 3 | Instruction field value to hold pending |
| df_load | input | 1 | Load the data field |
| df_val | input | 3 | Data field value |
| phys_addr | output | 15 | Registered physical address |
| addr_valid | output | 1 | phys_addr and next_pc belong to an access |
| next_pc | output | 12 | Registered program counter for the next step |

## Verification
A wrong field register shows up only in bits 14:12 of phys_addr. It is seen on the first fetch or data access after the fault, which is one clock after that access is presented. A pending field that commits too early or too late shows up as a field change on the wrong fetch around a jump, so the bench brackets every jump with fetches on both sides. A carry leaking from the PC into the field is caught by a fetch at 4095 followed by one at 0. A wrong page select shows up in bits 11:7 of a data address.

// File: rtl/fext_pkg.sv
package fext_pkg;
  typedef enum logic {
    CYC_FETCH = 1'b0,
    CYC_DATA  = 1'b1
  } cyc_kind_e;
endpackage

// File: rtl/fext_ea.sv
module fext_ea #(
  parameter int PC_W  = 12,
  parameter int OFS_W = 7
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFS_W-1:0] ofs,
  input  logic             cur_page,
  output logic [PC_W-1:0]  ea
);
  localparam int PG_W = PC_W - OFS_W;

  logic [PG_W-1:0] page_bits;

  always_comb begin
    page_bits = cur_page ? pc[PC_W-1:OFS_W] : '0;
    ea        = {page_bits, ofs};
  end
endmodule

// File: rtl/fext_fields.sv
module fext_fields #(
  parameter int FLD_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             jump,
  input  logic             if_load,
  input  logic [FLD_W-1:0] if_val,
  input  logic             df_load,
  input  logic [FLD_W-1:0] df_val,
  output logic [FLD_W-1:0] if_q,
  output logic [FLD_W-1:0] df_q
);
  logic [FLD_W-1:0] if_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      if_q    <= '0;
      if_pend <= '0;
      df_q    <= '0;
    end else if (step) begin
      if (jump)    if_q    <= if_pend;
      if (if_load) if_pend <= if_val;
      if (df_load) df_q    <= df_val;
    end
  end
endmodule

// File: rtl/fext_pc_next.sv
module fext_pc_next #(
  parameter int PC_W = 12
) (
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] ea,
  input  logic            jump,
  output logic [PC_W-1:0] npc
);
  localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

  always_comb begin
    npc = jump ? ea : pc + PC_ONE;
  end
endmodule

// File: rtl/fext_addr_unit.sv
module fext_addr_unit #(
  parameter int PC_W  = 12,
  parameter int OFS_W = 7,
  parameter int FLD_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_en,
  input  logic                  acc_data,
  input  logic [PC_W-1:0]       pc_in,
  input  logic [OFS_W-1:0]      ofs,
  input  logic                  cur_page,
  input  logic                  jump_en,
  input  logic                  if_load,
  input  logic [FLD_W-1:0]      if_val,
  input  logic                  df_load,
  input  logic [FLD_W-1:0]      df_val,
  output logic [FLD_W+PC_W-1:0] phys_addr,
  output logic                  addr_valid,
  output logic [PC_W-1:0]       next_pc
);
  import fext_pkg::*;

  localparam int PA_W = FLD_W + PC_W;

  cyc_kind_e        kind;
  logic [PC_W-1:0]  ea;
  logic [PC_W-1:0]  npc_c;
  logic [FLD_W-1:0] if_q;
  logic [FLD_W-1:0] df_q;
  logic [PA_W-1:0]  phys_c;

  assign kind = cyc_kind_e'(acc_data);

  fext_ea #(.PC_W(PC_W), .OFS_W(OFS_W)) u_ea (
    .pc       (pc_in),
    .ofs      (ofs),
    .cur_page (cur_page),
    .ea       (ea)
  );

  fext_fields #(.FLD_W(FLD_W)) u_fields (
    .clk     (clk),
    .rst     (rst),
    .step    (acc_en),
    .jump    (jump_en),
    .if_load (if_load),
    .if_val  (if_val),
    .df_load (df_load),
    .df_val  (df_val),
    .if_q    (if_q),
    .df_q    (df_q)
  );

  fext_pc_next #(.PC_W(PC_W)) u_pc (
    .pc   (pc_in),
    .ea   (ea),
    .jump (jump_en),
    .npc  (npc_c)
  );

  always_comb begin
    if (kind == CYC_DATA) phys_c = {df_q, ea};
    else                  phys_c = {if_q, pc_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr  <= '0;
      addr_valid <= 1'b0;
      next_pc    <= '0;
    end else begin
      addr_valid <= acc_en;
      if (acc_en) begin
        phys_addr <= phys_c;
        next_pc   <= npc_c;
      end
    end
  end
endmodule

// File: rtl/fext_addr_chk.sv
module fext_addr_chk #(
  parameter int PC_W  = 12,
  parameter int OFS_W = 7,
  parameter int FLD_W = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  acc_en,
  input logic                  acc_data,
  input logic [PC_W-1:0]       pc_in,
  input logic [OFS_W-1:0]      ofs,
  input logic                  cur_page,
  input logic                  jump_en,
  input logic [FLD_W+PC_W-1:0] phys_addr,
  input logic                  addr_valid,
  input logic [PC_W-1:0]       next_pc
);
  localparam int PA_W = FLD_W + PC_W;
  localparam int PG_W = PC_W - OFS_W;
  localparam logic [PC_W-1:0] ONE_W = {{(PC_W-1){1'b0}}, 1'b1};

  assert_valid_R2: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> addr_valid);

  assert_fetch_low_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_data) |=> (phys_addr[PC_W-1:0] == $past(pc_in)));

  assert_page_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_data && !cur_page) |=>
      (phys_addr[PC_W-1:0] == {{PG_W{1'b0}}, $past(ofs)}));

  assert_cur_page_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_data && cur_page) |=>
      (phys_addr[PC_W-1:0] == {$past(pc_in[PC_W-1:OFS_W]), $past(ofs)}));

  assert_pc_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !jump_en) |=> (next_pc == $past(pc_in) + ONE_W));

  assert_field_steady_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_data && !jump_en) ##1 (acc_en && !acc_data) |=>
      (phys_addr[PA_W-1:PC_W] == $past(phys_addr[PA_W-1:PC_W])));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> (!addr_valid && $stable(phys_addr) && $stable(next_pc)));
endmodule

bind fext_addr_unit fext_addr_chk #(.PC_W(PC_W), .OFS_W(OFS_W), .FLD_W(FLD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_en     (acc_en),
  .acc_data   (acc_data),
  .pc_in      (pc_in),
  .ofs        (ofs),
  .cur_page   (cur_page),
  .jump_en    (jump_en),
  .phys_addr  (phys_addr),
  .addr_valid (addr_valid),
  .next_pc    (next_pc)
);

// File: tb/tb_fext_addr_unit.sv
`timescale 1ns/1ps
module tb_fext_addr_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_en, acc_data, cur_page, jump_en, if_load, df_load;
  logic [11:0] pc_in;
  logic [6:0]  ofs;
  logic [2:0]  if_val, df_val;
  logic [14:0] phys_addr;
  logic        addr_valid;
  logic [11:0] next_pc;

  always #5 clk = ~clk;

  fext_addr_unit dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_data(acc_data),
    .pc_in(pc_in), .ofs(ofs), .cur_page(cur_page), .jump_en(jump_en),
    .if_load(if_load), .if_val(if_val), .df_load(df_load), .df_val(df_val),
    .phys_addr(phys_addr), .addr_valid(addr_valid), .next_pc(next_pc)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [14:0] q_phys[$];
  logic [11:0] q_npc[$];
  string       q_tag[$];

  logic [2:0]  m_if = 3'd0, m_pend = 3'd0, m_df = 3'd0;
  logic [14:0] m_last_phys = '0;
  logic [11:0] m_last_npc = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit dat, input logic [11:0] pc, input logic [6:0] o,
                        input bit cp, input bit jmp, input bit ldi, input logic [2:0] iv,
                        input bit ldd, input logic [2:0] dv, input string tag);
    logic [11:0] ea;
    logic [14:0] ph;
    logic [11:0] np;
    @(negedge clk);
    acc_en = 1'b1; acc_data = dat; pc_in = pc; ofs = o; cur_page = cp;
    jump_en = jmp; if_load = ldi; if_val = iv; df_load = ldd; df_val = dv;
    ea = cp ? {pc[11:7], o} : {5'b0, o};
    ph = dat ? {m_df, ea} : {m_if, pc};
    np = jmp ? ea : pc + 12'd1;
    q_phys.push_back(ph); q_npc.push_back(np); q_tag.push_back(tag);
    m_last_phys = ph; m_last_npc = np;
    if (jmp) m_if = m_pend;
    if (ldi) m_pend = iv;
    if (ldd) m_df = dv;
  endtask

  task automatic fetch(input logic [11:0] pc, input string tag);
    access(1'b0, pc, 7'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, tag);
  endtask

  task automatic idle_jump();
    @(negedge clk);
    acc_en = 1'b0; jump_en = 1'b1; if_load = 1'b0; df_load = 1'b0;
    @(negedge clk);
    check("R10 valid low", {31'b0, addr_valid}, 32'd0);
    check("R10 phys hold", {17'b0, phys_addr}, {17'b0, m_last_phys});
    check("R10 npc hold", {20'b0, next_pc}, {20'b0, m_last_npc});
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (!rst && addr_valid && !done) begin
      if (q_phys.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2: unexpected valid, actual %0h expected none", phys_addr);
      end else begin
        string t;
        logic [14:0] ep;
        logic [11:0] en;
        t = q_tag.pop_front(); ep = q_phys.pop_front(); en = q_npc.pop_front();
        check({t, " phys"}, {17'b0, phys_addr}, {17'b0, ep});
        check({t, " npc"}, {20'b0, next_pc}, {20'b0, en});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; acc_en = 1'b0; acc_data = 1'b0; pc_in = '0; ofs = '0; cur_page = 1'b0;
    jump_en = 1'b0; if_load = 1'b0; if_val = '0; df_load = 1'b0; df_val = '0;
    repeat (3) @(negedge clk);
    check("R1 valid", {31'b0, addr_valid}, 32'd0);
    check("R1 phys", {17'b0, phys_addr}, 32'd0);
    check("R1 npc", {20'b0, next_pc}, 32'd0);
    rst = 1'b0;

    fetch(12'h005, "R1 R2 first fetch");
    access(1'b1, 12'h3A5, 7'h12, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, "R3 page zero");
    access(1'b0, 12'h3A6, 7'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd5, "R9 df load on fetch");
    access(1'b1, 12'hABC, 7'h7F, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, "R4 R9 current page");
    access(1'b0, 12'h100, 7'h00, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 3'd0, "R7 load pending");
    fetch(12'h101, "R7 old field kept");
    access(1'b0, 12'h102, 7'h20, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, "R6 R7 jump cycle");
    fetch(12'h120, "R7 new field");
    fetch(12'hFFF, "R5 top of field");
    fetch(12'h000, "R5 wrapped");
    access(1'b0, 12'h001, 7'h44, 1'b0, 1'b1, 1'b1, 3'd6, 1'b0, 3'd0, "R6 R8 load with jump");
    fetch(12'h044, "R8 previous pending");
    access(1'b0, 12'h045, 7'h10, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 3'd0, "R8 second jump");
    fetch(12'h010, "R8 field six");
    idle_jump();
    fetch(12'h011, "R10 idle jump ignored");
    access(1'b1, 12'h011, 7'h05, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2, "R9 same cycle old df");
    access(1'b1, 12'h011, 7'h05, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, "R9 new df");
    for (int i = 0; i < 16; i++) begin
      access(1'b1, 12'(i * 263), 7'(i * 37), i[0], 1'b0, 1'b0, 3'd0, 1'b1, 3'(i), "R3 R4 sweep");
    end
    idle_jump();
    repeat (3) @(negedge clk);
    if (q_phys.size() != 0) check("R2 drained", q_phys.size(), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule